// File: doc/BRIEF.md
# Flash Sector Protection Guard

This block sits beside the command sequencer of a flash array split into several equal blocks, and it rules on every program or erase request before the request starts. Each flash block has its own 8-bit protection register. The register carries a mode flag, a read-only reserved bit, and two address ranges. One range is anchored at the top of the block and the other at the bottom. Each range has a disable bit and a 2-bit size code. While reset is held, every register is loaded from the nonvolatile configuration byte that the flash presents on `cfg_byte`. After reset, software can read a register over a small register bus and may only tighten it.

The mode flag sets what the ranges mean. When the flag is 1, the enabled ranges are the only protected regions. When the flag is 0, the enabled ranges are the only writable windows, and the rest of the block is locked, which leaves room for emulated EEPROM. A request that touches a protected address is denied. So is a whole-block erase of a block that contains any protected sector. A denial sets a sticky violation flag. While that flag is set, every later request is denied, until software clears the flag by writing 1 to it.

Top module: `flash_prot_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, every block register loads `cfg_byte` and the violation flag clears. Afterwards, each register reads back that byte.
- R2: Bit 6 of a protection register is read-only. A write never changes it.
- R3: Bit 7 (the mode flag: 1 = ranges protect, 0 = ranges are windows) is fixed at reset. A write never changes it.
- R4: In mode 1, an offset is protected exactly when it lies in an enabled range. The high range covers the top 2^(11+code) bytes of the block, set by bits 4:3. The low range covers the bottom 2^(9+code) bytes, set by bits 1:0.
- R5: In mode 0, an offset is protected exactly when it lies outside every enabled range. The range sizes are the same as in R4.
- R6: A disable bit of 1 (bit 5 for the high range, bit 2 for the low range) removes that range. In mode 1 it protects nothing. In mode 0 it opens nothing.
- R7: A mass erase (`cmd_mass`=1) is allowed only when the target block has no protected sector. That means mode 1 with both ranges disabled.
- R8: While `cmd_valid` is high, exactly one of `cmd_allow` and `cmd_deny` is high in the same cycle. Both are low otherwise. A deny sets `viol_flag` at the next edge.
- R9: `viol_flag` stays set until software writes 1 to bit 0 at register address 1. Writing 0 has no effect. A deny in the same cycle as a clear leaves the flag set.
- R10: While `viol_flag` is set, every request is denied.
- R11: In mode 1, a write is applied only if no range loses protection. A range may go from disabled to enabled. An enabled range may stay enabled with an equal or larger code. Any other change causes the whole write to be ignored.
- R12: In mode 0, a write is applied only if no window grows. A window may become disabled. An enabled window may stay enabled with an equal or smaller code. Any other change causes the whole write to be ignored.
- R13: `bank_sel` codes 0 to 3 select the register of block 0 to 3 for reads and writes at register address 0. A request is judged by the register of `cmd_block`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads registers from `cfg_byte` |
| cfg_byte | input | 8 | Nonvolatile configuration byte presented during reset |
| bank_sel | input | 2 | Block whose register the bus sees |
| reg_addr | input | 1 | 0 = protection register, 1 = status (bit 0 violation flag) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cmd_valid | input | 1 | A program or erase request is presented |
| cmd_mass | input | 1 | 1 = mass erase of the whole block |
| cmd_block | input | 2 | Target flash block |
| cmd_offset | input | 17 | Byte offset inside the target block |
| cmd_allow | output | 1 | Request may proceed |
| cmd_deny | output | 1 | Request refused |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
On every cycle, the assertions check the request handshake: allow and deny never both high, and exactly one high while a request is valid. They also check that a deny sets the flag, that the flag holds until a clearing write, that requests are refused while it is set, and that bits 7 and 6 of every block register keep their reset value. The address decoding of both modes, mass-erase refusal, the write filter that only tightens protection, and bank steering depend on chosen configurations and offsets. The bench scenarios show those, with expected results worked out from the range sizes.

// File: rtl/flg_pkg.sv
// Shared types for the flash protection guard.
// Assumes the 8-bit register layout that the rest of the block decodes.
package flg_pkg;
    typedef struct packed {
        logic       open_mode;  // 1: ranges protect, 0: ranges are windows
        logic       rsv;        // reserved nonvolatile bit, read-only
        logic       hi_dis;     // high range off
        logic [1:0] hi_sz;      // high range size code
        logic       lo_dis;     // low range off
        logic [1:0] lo_sz;      // low range size code
    } prot_t;
endpackage

// File: rtl/flg_range_hit.sv
// Tells whether an offset falls inside a power-of-two range that is anchored
// at one end of a flash block. The range size is 2^(BASE_LOG + size_code) bytes.
// Assumes BASE_LOG + 3 < OFF_W, so that the largest range is smaller than the block.
module flg_range_hit #(
    parameter int OFF_W    = 17,
    parameter int BASE_LOG = 11,
    parameter bit AT_TOP   = 1'b1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size_code,
    output logic             hit
);
    localparam logic [OFF_W-1:0] ALL_ONES = {OFF_W{1'b1}};

    generate
        if (AT_TOP) begin : g_top
            // Top-anchored: every bit above the range size is one.
            always_comb begin
                hit = ((offset >> (BASE_LOG + int'(size_code))) ==
                       (ALL_ONES >> (BASE_LOG + int'(size_code))));
            end
        end else begin : g_bottom
            // Bottom-anchored: every bit above the range size is zero.
            always_comb begin
                hit = ((offset >> (BASE_LOG + int'(size_code))) == '0);
            end
        end
    endgenerate
endmodule

// File: rtl/flg_decide.sv
// Works out whether one request hits protected flash under one block's setting.
// A single-sector request checks the offset. A mass erase is refused when any
// part of the block is protected.
// Assumes the two ranges together never cover the whole block.
module flg_decide #(
    parameter int OFF_W   = 17,
    parameter int HI_LOG  = 11,
    parameter int LO_LOG  = 9
) (
    input  logic             open_mode,
    input  logic             hi_dis,
    input  logic [1:0]       hi_sz,
    input  logic             lo_dis,
    input  logic [1:0]       lo_sz,
    input  logic             mass,
    input  logic [OFF_W-1:0] offset,
    output logic             blocked
);
    logic hi_hit;
    logic lo_hit;
    logic in_range;

    flg_range_hit #(.OFF_W(OFF_W), .BASE_LOG(HI_LOG), .AT_TOP(1'b1)) u_hi (
        .offset(offset), .size_code(hi_sz), .hit(hi_hit)
    );

    flg_range_hit #(.OFF_W(OFF_W), .BASE_LOG(LO_LOG), .AT_TOP(1'b0)) u_lo (
        .offset(offset), .size_code(lo_sz), .hit(lo_hit)
    );

    // Combine the range hits according to the mode and request kind.
    always_comb begin
        in_range = (!hi_dis && hi_hit) || (!lo_dis && lo_hit);
        if (mass) begin
            blocked = open_mode ? !(hi_dis && lo_dis) : 1'b1;
        end else begin
            blocked = open_mode ? in_range : !in_range;
        end
    end
endmodule

// File: rtl/flg_prot_reg.sv
// Protection register for one flash block. It loads the configuration byte
// while reset is low. After that, it takes a write only when the write leaves
// every address at least as protected as before. Bits 7 and 6 never change
// after reset.
module flg_prot_reg
    import flg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_byte,
    input  logic       wr_en,
    input  logic [5:0] wdata_lo,
    output prot_t      prot_q
);
    prot_t cand;
    logic  hi_ok;
    logic  lo_ok;

    // Build the candidate value and judge each range against the current one.
    always_comb begin
        cand = prot_t'({prot_q.open_mode, prot_q.rsv, wdata_lo});
        if (prot_q.open_mode) begin
            hi_ok = prot_q.hi_dis ||
                    (!cand.hi_dis && (cand.hi_sz >= prot_q.hi_sz));
            lo_ok = prot_q.lo_dis ||
                    (!cand.lo_dis && (cand.lo_sz >= prot_q.lo_sz));
        end else begin
            hi_ok = cand.hi_dis ||
                    (!prot_q.hi_dis && (cand.hi_sz <= prot_q.hi_sz));
            lo_ok = cand.lo_dis ||
                    (!prot_q.lo_dis && (cand.lo_sz <= prot_q.lo_sz));
        end
    end

    // Load at reset, then apply only writes that tighten protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= prot_t'(cfg_byte);
        end else if (wr_en && hi_ok && lo_ok) begin
            prot_q <= cand;
        end
    end
endmodule

// File: rtl/flash_prot_guard.sv
// Top of the flash protection guard. It holds one protection register per
// flash block, a register bus steered by the bank select, a per-request
// allow/deny decision, and a sticky violation flag that is cleared by writing 1.
// Assumes NUM_BLOCKS is a power of two and that requests are judged in the
// cycle they are presented.
module flash_prot_guard
    import flg_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int OFF_W      = 17,
    parameter int HI_LOG     = 11,
    parameter int LO_LOG     = 9,
    localparam int BSEL_W    = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_byte,
    input  logic [BSEL_W-1:0] bank_sel,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cmd_valid,
    input  logic              cmd_mass,
    input  logic [BSEL_W-1:0] cmd_block,
    input  logic [OFF_W-1:0]  cmd_offset,
    output logic              cmd_allow,
    output logic              cmd_deny,
    output logic              viol_flag
);
    prot_t                     blk_q [NUM_BLOCKS];
    logic [8*NUM_BLOCKS-1:0]   prot_flat;
    prot_t                     cmd_prot;
    logic                      blocked;
    logic                      viol_q;
    logic                      clear_req;

    generate
        for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
            flg_prot_reg u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_byte (cfg_byte),
                .wr_en    (reg_wr && !reg_addr && (bank_sel == BSEL_W'(b))),
                .wdata_lo (reg_wdata[5:0]),
                .prot_q   (blk_q[b])
            );
            assign prot_flat[8*b +: 8] = blk_q[b];
        end
    endgenerate

    // Read mux: the protection register of the selected bank, or the status register.
    always_comb begin
        reg_rdata = reg_addr ? {7'b0, viol_q} : 8'(blk_q[bank_sel]);
    end

    assign cmd_prot = blk_q[cmd_block];

    flg_decide #(.OFF_W(OFF_W), .HI_LOG(HI_LOG), .LO_LOG(LO_LOG)) u_decide (
        .open_mode (cmd_prot.open_mode),
        .hi_dis    (cmd_prot.hi_dis),
        .hi_sz     (cmd_prot.hi_sz),
        .lo_dis    (cmd_prot.lo_dis),
        .lo_sz     (cmd_prot.lo_sz),
        .mass      (cmd_mass),
        .offset    (cmd_offset),
        .blocked   (blocked)
    );

    // Request verdict: denied when the flag is pending or the target is protected.
    always_comb begin
        cmd_deny  = cmd_valid && (viol_q || blocked);
        cmd_allow = cmd_valid && !viol_q && !blocked;
        clear_req = reg_wr && reg_addr && reg_wdata[0];
    end

    // Sticky violation flag: a deny sets it, a write of 1 clears it, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (cmd_deny) begin
            viol_q <= 1'b1;
        end else if (clear_req) begin
            viol_q <= 1'b0;
        end
    end

    assign viol_flag = viol_q;
endmodule

// File: rtl/flg_guard_chk.sv
// Cycle-by-cycle checks on the flash protection guard, attached by bind.
module flg_guard_chk #(
    parameter int NUM_BLOCKS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [7:0]              cfg_byte,
    input logic                    reg_wr,
    input logic                    reg_addr,
    input logic [7:0]              reg_wdata,
    input logic                    cmd_valid,
    input logic                    cmd_allow,
    input logic                    cmd_deny,
    input logic                    viol_flag,
    input logic [8*NUM_BLOCKS-1:0] prot_flat
);
    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_allow && cmd_deny));

    // R8
    verdict_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_allow || cmd_deny) == cmd_valid);

    // R8
    deny_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_deny |=> viol_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !(reg_wr && reg_addr && reg_wdata[0])) |=> viol_flag);

    // R10
    flag_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && cmd_valid) |-> cmd_deny);

    // R1
    reset_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !viol_flag);

    generate
        for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
            // R1
            reset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> (prot_flat[8*b +: 8] == $past(cfg_byte)));

            // R2
            rsv_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> $stable(prot_flat[8*b+6]));

            // R3
            mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> $stable(prot_flat[8*b+7]));
        end
    endgenerate
endmodule

bind flash_prot_guard flg_guard_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_byte  (cfg_byte),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmd_valid (cmd_valid),
    .cmd_allow (cmd_allow),
    .cmd_deny  (cmd_deny),
    .viol_flag (viol_flag),
    .prot_flat (prot_flat)
);

// File: tb/test_flash_prot_guard.sv
module test_flash_prot_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_byte = 8'hFF;
    logic [1:0]  bank_sel = '0;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_mass = 1'b0;
    logic [1:0]  cmd_block = '0;
    logic [16:0] cmd_offset = '0;
    logic        cmd_allow;
    logic        cmd_deny;
    logic        viol_flag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    flash_prot_guard i_flash_prot_guard (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .bank_sel(bank_sel),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_mass(cmd_mass),
        .cmd_block(cmd_block), .cmd_offset(cmd_offset), .cmd_allow(cmd_allow),
        .cmd_deny(cmd_deny), .viol_flag(viol_flag)
    );

    // Vector fields: cfg[26:19], mass[18], offset[17:1], expected allow[0]
    localparam int NV = 23;
    localparam logic [26:0] VEC [NV] = '{
        {8'hFF, 1'b0, 17'h00000, 1'b1},
        {8'hFF, 1'b0, 17'h1FFFF, 1'b1},
        {8'hFF, 1'b1, 17'h00000, 1'b1},
        {8'hCC, 1'b0, 17'h1F000, 1'b0},
        {8'hCC, 1'b0, 17'h1EFFF, 1'b1},
        {8'hCC, 1'b0, 17'h00000, 1'b1},
        {8'hCC, 1'b1, 17'h00000, 1'b0},
        {8'hE2, 1'b0, 17'h007FF, 1'b0},
        {8'hE2, 1'b0, 17'h00800, 1'b1},
        {8'hE2, 1'b0, 17'h1FFFF, 1'b1},
        {8'hE2, 1'b1, 17'h00000, 1'b0},
        {8'hE0, 1'b0, 17'h001FF, 1'b0},
        {8'hE0, 1'b0, 17'h00200, 1'b1},
        {8'hDC, 1'b0, 17'h1C000, 1'b0},
        {8'hDC, 1'b0, 17'h1BFFF, 1'b1},
        {8'h43, 1'b0, 17'h1F800, 1'b1},
        {8'h43, 1'b0, 17'h1F7FF, 1'b0},
        {8'h43, 1'b0, 17'h00FFF, 1'b1},
        {8'h43, 1'b0, 17'h01000, 1'b0},
        {8'h43, 1'b1, 17'h00000, 1'b0},
        {8'h64, 1'b0, 17'h00000, 1'b0},
        {8'h64, 1'b0, 17'h1FFFF, 1'b0},
        {8'h64, 1'b1, 17'h00000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_byte = c;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] bank, input logic a, input logic [7:0] d);
        @(negedge clk);
        bank_sel = bank; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] bank, input logic a, output logic [7:0] d);
        @(negedge clk);
        bank_sel = bank; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Present a request for one cycle. Returns allow, deny, and the flag after the edge.
    task automatic cmd(input logic [1:0] blk, input logic mass, input logic [16:0] off,
                       output logic al, output logic dn, output logic fl);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_block = blk; cmd_mass = mass; cmd_offset = off;
        #1 al = cmd_allow; dn = cmd_deny;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1 fl = viol_flag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic al, dn, fl;

        // R1: reset loads every block and clears the flag
        do_reset(8'hA5);
        for (int b = 0; b < 4; b++) begin
            rd(2'(b), 1'b0, d);
            check("R1 reset load", 32'(d), 32'hA5);
        end
        rd(2'd0, 1'b1, d);
        check("R1 flag clear", 32'(d), 32'h00);
        #1 check("R8 idle verdict", {30'b0, cmd_allow, cmd_deny}, 32'h0);

        // Table walk: R4 / R5 / R6 / R7
        for (int i = 0; i < NV; i++) begin
            string tag;
            logic [26:0] v;
            v = VEC[i];
            tag = v[18] ? "R7" : ((v[24] && v[21]) ? "R6" : (v[26] ? "R4" : "R5"));
            do_reset(v[26:19]);
            cmd(2'd2, v[18], v[17:1], al, dn, fl);
            check(tag, {30'b0, al, dn}, {30'b0, v[0], !v[0]});
            check("R8 flag after verdict", 32'(fl), 32'(!v[0]));
        end

        // R2 / R3 / R11: the mode and reserved bits hold; enabling ranges is taken
        do_reset(8'hFF);
        wr(2'd0, 1'b0, 8'h00);
        rd(2'd0, 1'b0, d);
        check("R2 R3 bits held", 32'(d), 32'hC0);
        wr(2'd0, 1'b0, 8'hE0);
        rd(2'd0, 1'b0, d);
        check("R11 disable rejected", 32'(d), 32'hC0);
        wr(2'd0, 1'b0, 8'hC8);
        rd(2'd0, 1'b0, d);
        check("R11 enlarge taken", 32'(d), 32'hC8);
        wr(2'd0, 1'b0, 8'hC0);
        rd(2'd0, 1'b0, d);
        check("R11 shrink rejected", 32'(d), 32'hC8);

        // R13: bank steering of writes and of request decisions
        do_reset(8'hFF);
        wr(2'd1, 1'b0, 8'hC7);
        rd(2'd1, 1'b0, d);
        check("R13 bank1 written", 32'(d), 32'hC7);
        rd(2'd0, 1'b0, d);
        check("R13 bank0 untouched", 32'(d), 32'hFF);
        cmd(2'd0, 1'b0, 17'h1F800, al, dn, fl);
        check("R13 block0 allowed", 32'(al), 32'h1);
        cmd(2'd1, 1'b0, 17'h1F800, al, dn, fl);
        check("R13 block1 denied", 32'(dn), 32'h1);

        // R9 / R10: sticky flag, refusal while set, clear by writing 1
        cmd(2'd0, 1'b0, 17'h00000, al, dn, fl);
        check("R10 denied while flag set", 32'(dn), 32'h1);
        wr(2'd0, 1'b1, 8'h00);
        rd(2'd0, 1'b1, d);
        check("R9 write 0 no clear", 32'(d), 32'h01);
        wr(2'd0, 1'b1, 8'h01);
        rd(2'd0, 1'b1, d);
        check("R9 write 1 clears", 32'(d), 32'h00);
        cmd(2'd0, 1'b0, 17'h00000, al, dn, fl);
        check("R9 allowed after clear", {30'b0, al, fl}, 32'h2);
        // R9: a deny in the same cycle as a clear leaves the flag set
        @(negedge clk);
        bank_sel = 2'd0; reg_addr = 1'b1; reg_wdata = 8'h01; reg_wr = 1'b1;
        cmd_valid = 1'b1; cmd_block = 2'd1; cmd_mass = 1'b0; cmd_offset = 17'h1FFFF;
        @(negedge clk);
        reg_wr = 1'b0; cmd_valid = 1'b0;
        #1 check("R9 set wins over clear", 32'(viol_flag), 32'h1);

        // R12: in mode 0 windows may only shrink or close
        do_reset(8'h43);
        wr(2'd3, 1'b0, 8'h42);
        rd(2'd3, 1'b0, d);
        check("R12 shrink taken", 32'(d), 32'h42);
        wr(2'd3, 1'b0, 8'h43);
        rd(2'd3, 1'b0, d);
        check("R12 grow rejected", 32'(d), 32'h42);
        wr(2'd3, 1'b0, 8'hC6);
        rd(2'd3, 1'b0, d);
        check("R12 close taken, R3 mode held", 32'(d), 32'h46);
        wr(2'd3, 1'b0, 8'h42);
        rd(2'd3, 1'b0, d);
        check("R12 reopen rejected", 32'(d), 32'h46);
        cmd(2'd3, 1'b0, 17'h00100, al, dn, fl);
        check("R12 closed window denies", 32'(dn), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule